// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows a USB device's endpoint-0 control transfer through its SETUP, data and status stages. It sees decoded token events and received-packet summaries from a packet engine, the direction and data-stage flags of the current request, and two bits set by firmware: a three-way status selector (valid, invalid, stall) and an end-of-packet flag that firmware clears once it has finished the transfer. In return it issues one-cycle handshake commands, a request to transmit a zero-length data packet, the DATA0/DATA1 PID it expects next, and an interrupt pulse for each data-stage transaction.

The block does not serialize packets or compute CRCs. It decides what the packet engine sends next. The status stage opens when a token arrives in the direction opposite to the request. The block then answers NAK until firmware clears the end-of-packet flag. A zero-length packet sent for an IN status stage must be acknowledged by the host within a bounded window. If no acknowledge arrives, the status stage stays open so the host can retry it.

Top module: `ctrl_ep_seq`

## Requirements
- R1: After reset, `hs_valid`, `zlp_req` and `ep0_irq` are low and `exp_data1` is 0.
- R2: A token is ignored if `tok_addr_ok` is 0, if `tok_ep` is not 0, or if `tok_err` is 1. Such a token produces no output and does not change the toggle or the stage.
- R3: A qualified SETUP token (`tok_kind`=2'b10) sets `exp_data1` to 1 in the next cycle. It starts a data stage when `has_data` is 1 and a status stage when `has_data` is 0.
- R4: In the data stage, a token that matches the request direction pulses `ep0_irq` and inverts `exp_data1`. IN is `tok_kind`=2'b01 and matches when `req_dir_in`=1. OUT is 2'b00 and matches when `req_dir_in`=0.
- R5: In the data stage, a token in the opposite direction opens the status stage with `exp_data1`=1. The status direction is OUT for a read and IN for a write. In the status stage, a token in the wrong direction yields STALL (`hs_code`=2'b10) and ends the transfer.
- R6: An IN status token with `cpu_stat`=2'b01 (invalid) produces no output and ends the transfer.
- R7: An IN status token with `cpu_stat`=2'b10 (stall) produces STALL and ends the transfer.
- R8: An IN status token with `cpu_stat`=2'b00 and `eop_pending`=1 produces NAK (`hs_code`=2'b01), and the status stage stays open.
- R9: An IN status token with `cpu_stat`=2'b00 and `eop_pending`=0 pulses `zlp_req` while `exp_data1` is 1.
- R10: A `hs_ack_in` pulse within `TMO_CYC` cycles of `zlp_req` completes the transfer, so later IN tokens get no response.
- R11: If no acknowledge arrives within `TMO_CYC` cycles, a late `hs_ack_in` is ignored and the status stage stays open, so the next IN token gets `zlp_req` again.
- R12: After an OUT status token, the next `pkt_valid` is handled as follows. A zero-length DATA1 packet gets ACK (`hs_code`=2'b00) and completes the transfer if `eop_pending`=0, and gets NAK otherwise. Any other packet gets STALL and ends the transfer.
- R13: A qualified SETUP token aborts any stage in progress and restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tok_valid | input | 1 | Token event strobe |
| tok_kind | input | 2 | 00 OUT, 01 IN, 10 SETUP |
| tok_addr_ok | input | 1 | Token address matches the device |
| tok_ep | input | EPW | Token endpoint number |
| tok_err | input | 1 | Token had a receive error |
| req_dir_in | input | 1 | Request is device-to-host (read) |
| has_data | input | 1 | Request has a data stage |
| cpu_stat | input | 2 | 00 valid, 01 invalid, 10 stall |
| eop_pending | input | 1 | Firmware has not yet cleared end-of-packet |
| pkt_valid | input | 1 | Received data packet strobe |
| pkt_data1 | input | 1 | Received packet carried DATA1 |
| pkt_zero_len | input | 1 | Received packet had zero length |
| hs_ack_in | input | 1 | Host ACK for a packet sent by the device |
| hs_valid | output | 1 | Handshake command strobe |
| hs_code | output | 2 | 00 ACK, 01 NAK, 10 STALL |
| zlp_req | output | 1 | Send a zero-length DATA1 packet |
| exp_data1 | output | 1 | Expected toggle: 1 for DATA1 |
| ep0_irq | output | 1 | Endpoint-0 data-stage interrupt pulse |

## Verification
The hardest case to reach is the IN status stage whose acknowledge times out. It can only be told apart from a normal completion by what happens afterwards. The stimulus sends the zero-length request, then idles for longer than the window before pulsing `hs_ack_in`. A following IN token must then produce `zlp_req` again. A second run acknowledges inside the window and must see silence on the retry.

// File: rtl/ctrl_ep_pkg.sv
package ctrl_ep_pkg;
    typedef enum logic [1:0] {TK_OUT = 2'b00, TK_IN = 2'b01, TK_SETUP = 2'b10} tok_e;
    typedef enum logic [1:0] {HS_ACK = 2'b00, HS_NAK = 2'b01, HS_STALL = 2'b10} hs_e;
    typedef enum logic [1:0] {CS_VALID = 2'b00, CS_INVALID = 2'b01, CS_STALL = 2'b10} cstat_e;
    typedef enum logic [1:0] {SG_IDLE, SG_DATA, SG_STATUS} stage_e;
    typedef enum logic [1:0] {PH_IDLE, PH_OUT_PKT, PH_WAIT_ACK} phase_e;

    typedef struct packed {
        stage_e stage;
        phase_e phase;
        logic   tog;
        logic   hs_v;
        hs_e    hs;
        logic   zlp;
        logic   irq;
    } seq_t;
endpackage

// File: rtl/ctrl_ep_tokchk.sv
module ctrl_ep_tokchk #(
    parameter int EPW = 4
) (
    input  logic           tok_valid,
    input  logic           tok_addr_ok,
    input  logic [EPW-1:0] tok_ep,
    input  logic           tok_err,
    output logic           tok_hit
);
    always_comb begin
        tok_hit = tok_valid && tok_addr_ok && !tok_err && (tok_ep == '0);
    end
endmodule

// File: rtl/ctrl_ep_tmo.sv
module ctrl_ep_tmo #(
    parameter int TMO_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = run ? cnt_q + 1'b1 : '0;
        expired = run && (cnt_q == TW'(TMO_CYC - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ctrl_ep_seq.sv
module ctrl_ep_seq
    import ctrl_ep_pkg::*;
#(
    parameter int EPW     = 4,
    parameter int TMO_CYC = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tok_valid,
    input  logic [1:0]     tok_kind,
    input  logic           tok_addr_ok,
    input  logic [EPW-1:0] tok_ep,
    input  logic           tok_err,
    input  logic           req_dir_in,
    input  logic           has_data,
    input  logic [1:0]     cpu_stat,
    input  logic           eop_pending,
    input  logic           pkt_valid,
    input  logic           pkt_data1,
    input  logic           pkt_zero_len,
    input  logic           hs_ack_in,
    output logic           hs_valid,
    output logic [1:0]     hs_code,
    output logic           zlp_req,
    output logic           exp_data1,
    output logic           ep0_irq
);
    seq_t s_d, s_q;
    logic tok_hit, tmo_expired, is_in, to_status;

    ctrl_ep_tokchk #(.EPW(EPW)) u_tokchk (
        .tok_valid   (tok_valid),
        .tok_addr_ok (tok_addr_ok),
        .tok_ep      (tok_ep),
        .tok_err     (tok_err),
        .tok_hit     (tok_hit)
    );

    ctrl_ep_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (s_q.phase == PH_WAIT_ACK),
        .expired (tmo_expired)
    );

    always_comb begin
        s_d       = s_q;
        s_d.hs_v  = 1'b0;
        s_d.hs    = HS_ACK;
        s_d.zlp   = 1'b0;
        s_d.irq   = 1'b0;
        is_in     = (tok_kind == TK_IN);
        to_status = 1'b0;

        if (tok_hit && tok_kind == TK_SETUP) begin
            s_d.stage = has_data ? SG_DATA : SG_STATUS;
            s_d.phase = PH_IDLE;
            s_d.tog   = 1'b1;
        end else if (tok_hit && tok_kind != TK_SETUP) begin
            s_d.phase = PH_IDLE;
            if (s_q.stage == SG_DATA) begin
                if (is_in == req_dir_in) begin
                    s_d.irq = 1'b1;
                    s_d.tog = ~s_q.tog;
                end else begin
                    s_d.stage = SG_STATUS;
                    s_d.tog   = 1'b1;
                    to_status = 1'b1;
                end
            end else if (s_q.stage == SG_STATUS) begin
                if (is_in == !req_dir_in) begin
                    to_status = 1'b1;
                end else begin
                    s_d.hs_v  = 1'b1;
                    s_d.hs    = HS_STALL;
                    s_d.stage = SG_IDLE;
                end
            end

            if (to_status) begin
                if (!is_in) begin
                    s_d.phase = PH_OUT_PKT;
                end else begin
                    unique case (cpu_stat)
                        CS_INVALID: s_d.stage = SG_IDLE;
                        CS_STALL: begin
                            s_d.hs_v  = 1'b1;
                            s_d.hs    = HS_STALL;
                            s_d.stage = SG_IDLE;
                        end
                        default: begin
                            if (eop_pending) begin
                                s_d.hs_v = 1'b1;
                                s_d.hs   = HS_NAK;
                            end else begin
                                s_d.zlp   = 1'b1;
                                s_d.phase = PH_WAIT_ACK;
                            end
                        end
                    endcase
                end
            end
        end else if (pkt_valid && s_q.phase == PH_OUT_PKT) begin
            s_d.phase = PH_IDLE;
            s_d.hs_v  = 1'b1;
            if (pkt_zero_len && pkt_data1) begin
                if (eop_pending) begin
                    s_d.hs = HS_NAK;
                end else begin
                    s_d.hs    = HS_ACK;
                    s_d.stage = SG_IDLE;
                end
            end else begin
                s_d.hs    = HS_STALL;
                s_d.stage = SG_IDLE;
            end
        end else if (s_q.phase == PH_WAIT_ACK) begin
            if (hs_ack_in) begin
                s_d.phase = PH_IDLE;
                s_d.stage = SG_IDLE;
            end else if (tmo_expired) begin
                s_d.phase = PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{stage: SG_IDLE, phase: PH_IDLE, tog: 1'b0, hs_v: 1'b0,
                     hs: HS_ACK, zlp: 1'b0, irq: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign hs_valid  = s_q.hs_v;
    assign hs_code   = s_q.hs;
    assign zlp_req   = s_q.zlp;
    assign exp_data1 = s_q.tog;
    assign ep0_irq   = s_q.irq;
endmodule

// File: rtl/ctrl_ep_seq_chk.sv
module ctrl_ep_seq_chk #(
    parameter int EPW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tok_valid,
    input logic [1:0]     tok_kind,
    input logic           tok_addr_ok,
    input logic [EPW-1:0] tok_ep,
    input logic           tok_err,
    input logic [1:0]     cpu_stat,
    input logic           eop_pending,
    input logic           pkt_valid,
    input logic           hs_valid,
    input logic [1:0]     hs_code,
    input logic           zlp_req,
    input logic           exp_data1,
    input logic           ep0_irq
);
    // R1: outputs are exclusive pulses
    a_r1_onehot_out: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hs_valid, zlp_req, ep0_irq}));

    // R2: an address mismatch alone gives no response
    a_r2_bad_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !tok_addr_ok && !pkt_valid) |=> (!ep0_irq && !zlp_req));

    // R3: SETUP arms DATA1
    a_r3_setup_data1: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 2'b10 && tok_addr_ok && !tok_err && tok_ep == '0)
        |=> exp_data1);

    // R4: interrupt comes with a toggle flip after a token
    a_r4_irq_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        ep0_irq |-> ($past(tok_valid) && exp_data1 != $past(exp_data1)));

    // R9: zero-length request only after a ready IN token, with DATA1
    a_r9_zlp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        zlp_req |-> ($past(tok_valid) && $past(tok_kind) == 2'b01
                     && !$past(eop_pending) && $past(cpu_stat) == 2'b00 && exp_data1));

    // R12: an ACK command needs a received packet with end-of-packet cleared
    a_r12_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_code == 2'b00) |-> ($past(pkt_valid) && !$past(eop_pending)));
endmodule

bind ctrl_ep_seq ctrl_ep_seq_chk #(.EPW(EPW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_valid   (tok_valid),
    .tok_kind    (tok_kind),
    .tok_addr_ok (tok_addr_ok),
    .tok_ep      (tok_ep),
    .tok_err     (tok_err),
    .cpu_stat    (cpu_stat),
    .eop_pending (eop_pending),
    .pkt_valid   (pkt_valid),
    .hs_valid    (hs_valid),
    .hs_code     (hs_code),
    .zlp_req     (zlp_req),
    .exp_data1   (exp_data1),
    .ep0_irq     (ep0_irq)
);

// File: tb/ctrl_ep_seq_tb.sv
module ctrl_ep_seq_tb;
    localparam int EPW = 4;
    localparam int TMO = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tok_valid = 0, tok_addr_ok = 1, tok_err = 0;
    logic [1:0] tok_kind = 0, cpu_stat = 0;
    logic [EPW-1:0] tok_ep = 0;
    logic req_dir_in = 0, has_data = 0, eop_pending = 1;
    logic pkt_valid = 0, pkt_data1 = 0, pkt_zero_len = 0, hs_ack_in = 0;
    logic hs_valid, zlp_req, exp_data1, ep0_irq;
    logic [1:0] hs_code;
    int checks = 0, errors = 0;
    logic [4:0] obs;

    localparam logic [4:0] NONE = 5'b0;
    localparam logic [4:0] IRQ = 5'b00001, ZLP = 5'b00010;
    localparam logic [4:0] ACK = 5'b10000, NAK = 5'b10100, STL = 5'b11000;

    always #5 clk = ~clk;

    ctrl_ep_seq #(.EPW(EPW), .TMO_CYC(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .tok_addr_ok(tok_addr_ok), .tok_ep(tok_ep), .tok_err(tok_err),
        .req_dir_in(req_dir_in), .has_data(has_data), .cpu_stat(cpu_stat),
        .eop_pending(eop_pending), .pkt_valid(pkt_valid), .pkt_data1(pkt_data1),
        .pkt_zero_len(pkt_zero_len), .hs_ack_in(hs_ack_in), .hs_valid(hs_valid),
        .hs_code(hs_code), .zlp_req(zlp_req), .exp_data1(exp_data1), .ep0_irq(ep0_irq)
    );

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_tog(input string tag, input logic exp);
        chk(tag, {4'b0, exp_data1}, {4'b0, exp});
    endtask

    task automatic tok(input logic [1:0] k, input logic ok = 1,
                       input logic [EPW-1:0] ep = 0, input logic er = 0);
        @(negedge clk);
        tok_valid = 1; tok_kind = k; tok_addr_ok = ok; tok_ep = ep; tok_err = er;
        @(negedge clk);
        obs = {hs_valid, hs_code, zlp_req, ep0_irq};
        tok_valid = 0; tok_addr_ok = 1; tok_ep = 0; tok_err = 0;
    endtask

    task automatic pkt(input logic d1, input logic zl);
        @(negedge clk);
        pkt_valid = 1; pkt_data1 = d1; pkt_zero_len = zl;
        @(negedge clk);
        obs = {hs_valid, hs_code, zlp_req, ep0_irq};
        pkt_valid = 0;
    endtask

    task automatic ack_after(input int gap);
        repeat (gap) @(negedge clk);
        hs_ack_in = 1;
        @(negedge clk);
        hs_ack_in = 0;
    endtask

    task automatic t_reset;
        chk("R1 reset outputs", {hs_valid, hs_code, zlp_req, ep0_irq}, NONE);
        chk_tog("R1 reset toggle", 1'b0);
    endtask

    task automatic t_control_read;
        req_dir_in = 1; has_data = 1; eop_pending = 1; cpu_stat = 0;
        tok(2'b10); chk("R3 setup quiet", obs, NONE); chk_tog("R3 setup DATA1", 1);
        tok(2'b01); chk("R4 data IN irq", obs, IRQ); chk_tog("R4 toggle flip", 0);
        tok(2'b01); chk("R4 data IN irq 2", obs, IRQ); chk_tog("R4 toggle flip 2", 1);
        tok(2'b01, 0); chk("R2 bad addr", obs, NONE); chk_tog("R2 toggle kept", 1);
        tok(2'b01, 1, 4'd3); chk("R2 other ep", obs, NONE);
        tok(2'b01, 1, 0, 1); chk("R2 errored token", obs, NONE); chk_tog("R2 toggle kept 2", 1);
        tok(2'b01); chk("R4 data IN irq 3", obs, IRQ); chk_tog("R4 toggle flip 3", 0);
        tok(2'b00); chk("R5 OUT opens status", obs, NONE); chk_tog("R5 status DATA1", 1);
        pkt(1, 1); chk("R12 NAK while eop pending", obs, NAK);
        eop_pending = 0;
        tok(2'b00); pkt(1, 1); chk("R12 ACK zero-length DATA1", obs, ACK);
        tok(2'b00); pkt(1, 1); chk("R12 transfer ended", obs, NONE);
    endtask

    task automatic t_control_write;
        req_dir_in = 0; has_data = 1; eop_pending = 1; cpu_stat = 0;
        tok(2'b10);
        tok(2'b00); chk("R4 data OUT irq", obs, IRQ);
        tok(2'b01); chk("R8 NAK eop pending", obs, NAK); chk_tog("R5 status DATA1", 1);
        tok(2'b01); chk("R8 still open", obs, NAK);
        eop_pending = 0;
        tok(2'b01); chk("R9 zlp request", obs, ZLP); chk_tog("R9 zlp DATA1", 1);
        ack_after(2);
        tok(2'b01); chk("R10 completed by ACK", obs, NONE);
    endtask

    task automatic t_write_nodata;
        req_dir_in = 0; has_data = 0; eop_pending = 0; cpu_stat = 0;
        tok(2'b10);
        tok(2'b00); chk("R5 wrong direction stall", obs, STL);
        tok(2'b01); chk("R5 ended after stall", obs, NONE);
        tok(2'b10); cpu_stat = 2'b01;
        tok(2'b01); chk("R6 invalid silent", obs, NONE);
        cpu_stat = 0;
        tok(2'b01); chk("R6 transfer dropped", obs, NONE);
        tok(2'b10); cpu_stat = 2'b10;
        tok(2'b01); chk("R7 stall status", obs, STL);
        cpu_stat = 0;
        tok(2'b01); chk("R7 transfer ended", obs, NONE);
    endtask

    task automatic t_timeout;
        req_dir_in = 0; has_data = 0; eop_pending = 0; cpu_stat = 0;
        tok(2'b10);
        tok(2'b01); chk("R11 first zlp", obs, ZLP);
        ack_after(TMO + 4);
        tok(2'b01); chk("R11 retry after timeout", obs, ZLP);
        ack_after(1);
        tok(2'b01); chk("R11 done after retry ACK", obs, NONE);
    endtask

    task automatic t_out_bad_and_abort;
        req_dir_in = 1; has_data = 1; eop_pending = 0; cpu_stat = 0;
        tok(2'b10); tok(2'b01);
        tok(2'b00); pkt(0, 1); chk("R12 DATA0 stall", obs, STL);
        tok(2'b10); tok(2'b00); pkt(1, 0); chk("R12 nonzero length stall", obs, STL);
        tok(2'b10); tok(2'b00); chk_tog("R13 in status", 1);
        tok(2'b10); chk("R13 setup quiet", obs, NONE); chk_tog("R13 setup DATA1", 1);
        tok(2'b01); chk("R13 back in data stage", obs, IRQ);
        has_data = 0; req_dir_in = 0;
        tok(2'b10); tok(2'b01); chk("R13 zlp before abort", obs, ZLP);
        tok(2'b10); ack_after(1);
        tok(2'b01); chk("R13 wait aborted, status open", obs, ZLP);
        ack_after(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        t_control_read();
        t_control_write();
        t_write_nodata();
        t_timeout();
        t_out_bad_and_abort();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule